// File: doc/BRIEF.md
# Multi-Format FP8 to Binary32 Widener

This block converts an 8-bit floating-point code into an exact IEEE binary32 word. A two-bit select picks one of three 8-bit layouts. The first is a 3-bit-exponent, 4-bit-mantissa layout with bias 3. The second is a 4-bit-exponent, 3-bit-mantissa layout with bias 7, which has infinity and a largest finite value of 240. The third is a 5-bit-exponent, 2-bit-mantissa layout with bias 15. Every 8-bit value fits in binary32, so the widening never rounds.

Subnormal codes are not treated as zero. The block finds the leading one of the mantissa and shifts it up into the hidden-bit place. It lowers the exponent by the same shift and then builds a normal binary32 value. Zeros, infinities and NaNs map to their binary32 forms.

The block has a plain valid/data interface with no back-pressure. It is used wherever narrow stored tensors are widened ahead of single-precision arithmetic. The result is registered, so each conversion takes one cycle.

Top module: `fp8w_widen`

## Requirements
- R1: While reset is asserted, and after reset is released with no valid input yet, `out_valid_o` is 0 and `out_word_o` is 32'h0000_0000.
- R2: `out_valid_o` equals `in_valid_i` from the previous rising clock edge. A result appears exactly one cycle after its code is accepted.
- R3: In a cycle where `in_valid_i` is 0, the code and select are ignored: `out_word_o` keeps its previous value.
- R4: Code bit 7 is the sign. The exponent field sits directly below the sign, and the mantissa fills the low bits. Select 0 means 3 exponent bits, 4 mantissa bits and bias 3. Select 1 means 4 exponent bits, 3 mantissa bits and bias 7. Select 2 means 5 exponent bits, 2 mantissa bits and bias 15. For a normal code (exponent field neither 0 nor all ones), the binary32 exponent is field − bias + 127. The mantissa goes to the top of the 23-bit fraction, and the sign is copied.
- R5: An exponent field of 0 with a nonzero mantissa is rebuilt exactly. The mantissa is shifted left until its leading one reaches the hidden-bit place, and the exponent is lowered by the shift count. The smallest positive values are 2^-6 (select 0, 32'h3C80_0000), 2^-9 (select 1, 32'h3B00_0000) and 2^-16 (select 2, 32'h3780_0000).
- R6: A code with a zero exponent field and a zero mantissa gives a binary32 zero with the input sign.
- R7: An all-ones exponent field with a zero mantissa gives a binary32 infinity with the input sign, in every format.
- R8: An all-ones exponent field with a nonzero mantissa gives the quiet NaN 32'h7FC0_0000, with bit 31 set to the input sign.
- R9: The largest finite values decode exactly. They are 15.5 for select 0 (32'h4178_0000), 240 for select 1 (32'h4370_0000) and 57344 for select 2 (32'h4760_0000).
- R10: Select value 3 is reserved. Any code converted under it gives 32'h7FC0_0000.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock, rising edge active |
| rst_ni | input | 1 | Asynchronous reset, active low |
| in_valid_i | input | 1 | Code and select are presented this cycle |
| in_fmt_i | input | 2 | Layout select: 0, 1, 2, or 3 (reserved) |
| in_code_i | input | 8 | 8-bit floating-point code |
| out_valid_o | output | 1 | Result word is new this cycle |
| out_word_o | output | 32 | Binary32 result, held between valid inputs |

## Verification
Every converted word is due exactly one rising edge after the edge that accepts its code, and `out_valid_o` follows the same single-cycle delay. The bench changes inputs on falling edges. It reads each result on the next falling edge, so exactly one rising edge lies between stimulus and sample. The hold and reset checks sample over several idle cycles, confirming that nothing changes while no valid input arrives.

// File: rtl/fp8w_pkg.sv
package fp8w_pkg;

  // Layout selector values; the numeric codes are part of the port contract.
  typedef enum logic [1:0] {
    FMT_E3M4 = 2'd0,
    FMT_E4M3 = 2'd1,
    FMT_E5M2 = 2'd2,
    FMT_RSVD = 2'd3
  } fmt_e;

  localparam int NUM_FMT    = 3;
  localparam int CODE_W     = 8;
  localparam int WORD_W     = 32;
  localparam int F32_FRAC_W = 23;
  localparam int F32_BIAS   = 127;

  localparam logic [WORD_W-1:0] QNAN_WORD = 32'h7FC0_0000;

  // One flag per input class; exactly one is set for a decoded code.
  typedef struct packed {
    logic zero;
    logic sub;
    logic norm;
    logic inf;
    logic nan;
  } kind_t;

  // Exponent width of lane idx; the mantissa takes the remaining bits.
  function automatic int fmt_ew(input int idx);
    case (idx)
      0:       return 3;
      1:       return 4;
      default: return 5;
    endcase
  endfunction

  function automatic int fmt_mw(input int idx);
    return CODE_W - 1 - fmt_ew(idx);
  endfunction

endpackage

// File: rtl/fp8w_subnorm.sv
// Leading-one normalizer for a subnormal mantissa. It reports how far the
// mantissa must move up so that its top set bit sits at the hidden position.
module fp8w_subnorm #(
  parameter int MW = 3,
  localparam int SW = $clog2(MW + 1)
) (
  input  logic [MW-1:0] man_i,
  output logic [SW-1:0] shift_o,
  output logic [MW-1:0] frac_o,
  output logic          hidden_o
);

  logic [MW:0] moved;

  // Scanning upward makes the highest set bit decide the shift.
  always_comb begin
    shift_o = '0;
    for (int b = 0; b < MW; b++) begin
      if (man_i[b]) shift_o = SW'(MW - b);
    end
  end

  assign moved    = {1'b0, man_i} << shift_o;
  assign hidden_o = moved[MW];
  assign frac_o   = moved[MW-1:0];

endmodule

// File: rtl/fp8w_lane.sv
// Combinational decoder for one 8-bit layout with EW exponent bits.
module fp8w_lane
  import fp8w_pkg::*;
#(
  parameter int EW = 4,
  parameter int MW = 3
) (
  input  logic [CODE_W-1:0] code_i,
  output logic [WORD_W-1:0] word_o,
  output kind_t             kind_o,
  output logic              hidden_ok_o
);

  localparam int BIAS = (1 << (EW - 1)) - 1;
  localparam int FPAD = F32_FRAC_W - MW;
  localparam int SW   = $clog2(MW + 1);

  logic          sign;
  logic [EW-1:0] expf;
  logic [MW-1:0] man;
  logic          e_zero, e_max, m_nz;
  logic [SW-1:0] sub_shift;
  logic [MW-1:0] sub_frac;
  logic          sub_hidden;
  logic [7:0]    e_norm, e_sub;

  assign sign = code_i[CODE_W-1];
  assign expf = code_i[MW+EW-1:MW];
  assign man  = code_i[MW-1:0];

  assign e_zero = ~|expf;
  assign e_max  = &expf;
  assign m_nz   = |man;

  fp8w_subnorm #(.MW(MW)) u_norm (
    .man_i   (man),
    .shift_o (sub_shift),
    .frac_o  (sub_frac),
    .hidden_o(sub_hidden)
  );

  // Rebias: normal uses the field, subnormal uses 1 - shift as its exponent.
  assign e_norm = 8'(int'(expf) + F32_BIAS - BIAS);
  assign e_sub  = 8'(1 + F32_BIAS - BIAS - int'(sub_shift));

  always_comb begin
    kind_o.zero = e_zero & ~m_nz;
    kind_o.sub  = e_zero & m_nz;
    kind_o.norm = ~e_zero & ~e_max;
    kind_o.inf  = e_max & ~m_nz;
    kind_o.nan  = e_max & m_nz;
  end

  always_comb begin
    if (kind_o.nan)       word_o = {sign, QNAN_WORD[WORD_W-2:0]};
    else if (kind_o.inf)  word_o = {sign, 8'hFF, {F32_FRAC_W{1'b0}}};
    else if (kind_o.zero) word_o = {sign, {(WORD_W-1){1'b0}}};
    else if (kind_o.sub)  word_o = {sign, e_sub, sub_frac, {FPAD{1'b0}}};
    else                  word_o = {sign, e_norm, man, {FPAD{1'b0}}};
  end

  // Internal event exported for the checker in the top level.
  assign hidden_ok_o = ~kind_o.sub | sub_hidden;

endmodule

// File: rtl/fp8w_widen.sv
module fp8w_widen
  import fp8w_pkg::*;
(
  input  logic        clk_i,
  input  logic        rst_ni,
  input  logic        in_valid_i,
  input  logic [1:0]  in_fmt_i,
  input  logic [7:0]  in_code_i,
  output logic        out_valid_o,
  output logic [31:0] out_word_o
);

  logic [WORD_W-1:0] lane_word [NUM_FMT];
  kind_t             lane_kind [NUM_FMT];
  logic              lane_hid  [NUM_FMT];

  fmt_e              fmt;
  logic [WORD_W-1:0] sel_word;
  kind_t             sel_kind;
  logic              sel_hid_ok;
  logic              sel_rsvd;

  logic              valid_q;
  logic [WORD_W-1:0] word_q;

  assign fmt      = fmt_e'(in_fmt_i);
  assign sel_rsvd = (fmt == FMT_RSVD);

  for (genvar g = 0; g < NUM_FMT; g++) begin : g_lane
    fp8w_lane #(
      .EW(fmt_ew(g)),
      .MW(fmt_mw(g))
    ) u_lane (
      .code_i     (in_code_i),
      .word_o     (lane_word[g]),
      .kind_o     (lane_kind[g]),
      .hidden_ok_o(lane_hid[g])
    );
  end

  always_comb begin
    sel_word   = QNAN_WORD;
    sel_kind   = '0;
    sel_hid_ok = 1'b1;
    for (int g = 0; g < NUM_FMT; g++) begin
      if (in_fmt_i == 2'(g)) begin
        sel_word   = lane_word[g];
        sel_kind   = lane_kind[g];
        sel_hid_ok = lane_hid[g];
      end
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      valid_q <= 1'b0;
      word_q  <= '0;
    end else begin
      valid_q <= in_valid_i;
      if (in_valid_i) word_q <= sel_word;
    end
  end

  assign out_valid_o = valid_q;
  assign out_word_o  = word_q;

  // R2: valid follows input valid after one edge.
  p_valid_lat_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    out_valid_o == $past(in_valid_i));

  // R3: idle cycles leave the result untouched.
  p_hold_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !in_valid_i |=> $stable(out_word_o));

  // R4: each defined layout classifies a code into exactly one class.
  p_one_kind_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (in_valid_i && !sel_rsvd) |-> $countones(sel_kind) == 1);

  // R4: the result sign is the code sign.
  p_sign_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (in_valid_i && !sel_rsvd) |=> out_word_o[31] == $past(in_code_i[7]));

  // R5: a subnormal leaves the normalizer with its hidden bit set.
  p_hidden_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    in_valid_i |-> sel_hid_ok);

  // R6: zero magnitude code gives zero magnitude result.
  p_zero_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (in_valid_i && !sel_rsvd && in_code_i[6:0] == 7'h00) |=> out_word_o[30:0] == 31'h0);

  // R8: NaN codes give the quiet NaN magnitude.
  p_nan_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (in_valid_i && !sel_rsvd && sel_kind.nan) |=> out_word_o[30:0] == QNAN_WORD[30:0]);

  // R10: the reserved select gives the positive quiet NaN.
  p_rsvd_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (in_valid_i && sel_rsvd) |=> out_word_o == QNAN_WORD);

endmodule

// File: tb/fp8w_widen_tb.sv
`timescale 1ns/1ps
module fp8w_widen_tb_top;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        in_valid = 1'b0;
  logic [1:0]  in_fmt = 2'd0;
  logic [7:0]  in_code = 8'h00;
  logic        out_valid;
  logic [31:0] out_word;

  int checks = 0;
  int errors = 0;
  bit done   = 1'b0;

  always #4 clk = ~clk;

  fp8w_widen dut_i (
    .clk_i      (clk),
    .rst_ni     (rst_n),
    .in_valid_i (in_valid),
    .in_fmt_i   (in_fmt),
    .in_code_i  (in_code),
    .out_valid_o(out_valid),
    .out_word_o (out_word)
  );

  // Row: {req[3:0], fmt[1:0], code[7:0], expected[31:0]}
  localparam int NV = 38;
  localparam logic [45:0] VEC [NV] = '{
    {4'd4, 2'd0, 8'h30, 32'h3F80_0000},
    {4'd5, 2'd0, 8'h0F, 32'h3E70_0000},
    {4'd5, 2'd0, 8'h01, 32'h3C80_0000},
    {4'd5, 2'd0, 8'h84, 32'hBD80_0000},
    {4'd9, 2'd0, 8'h6F, 32'h4178_0000},
    {4'd7, 2'd0, 8'h70, 32'h7F80_0000},
    {4'd7, 2'd0, 8'hF0, 32'hFF80_0000},
    {4'd8, 2'd0, 8'h75, 32'h7FC0_0000},
    {4'd6, 2'd0, 8'h80, 32'h8000_0000},
    {4'd4, 2'd1, 8'h38, 32'h3F80_0000},
    {4'd4, 2'd1, 8'hC4, 32'hC040_0000},
    {4'd4, 2'd1, 8'h08, 32'h3C80_0000},
    {4'd9, 2'd1, 8'h77, 32'h4370_0000},
    {4'd7, 2'd1, 8'h78, 32'h7F80_0000},
    {4'd7, 2'd1, 8'hF8, 32'hFF80_0000},
    {4'd8, 2'd1, 8'h79, 32'h7FC0_0000},
    {4'd8, 2'd1, 8'hFF, 32'hFFC0_0000},
    {4'd5, 2'd1, 8'h01, 32'h3B00_0000},
    {4'd5, 2'd1, 8'h07, 32'h3C60_0000},
    {4'd5, 2'd1, 8'h03, 32'h3BC0_0000},
    {4'd6, 2'd1, 8'h00, 32'h0000_0000},
    {4'd4, 2'd2, 8'h3C, 32'h3F80_0000},
    {4'd4, 2'd2, 8'h04, 32'h3880_0000},
    {4'd9, 2'd2, 8'h7B, 32'h4760_0000},
    {4'd7, 2'd2, 8'h7C, 32'h7F80_0000},
    {4'd7, 2'd2, 8'hFC, 32'hFF80_0000},
    {4'd8, 2'd2, 8'h7D, 32'h7FC0_0000},
    {4'd8, 2'd2, 8'hFE, 32'hFFC0_0000},
    {4'd5, 2'd2, 8'h01, 32'h3780_0000},
    {4'd5, 2'd2, 8'h02, 32'h3800_0000},
    {4'd5, 2'd2, 8'h03, 32'h3840_0000},
    {4'd5, 2'd2, 8'h83, 32'hB840_0000},
    {4'd6, 2'd2, 8'h00, 32'h0000_0000},
    {4'd6, 2'd2, 8'h80, 32'h8000_0000},
    {4'd10, 2'd3, 8'h3C, 32'h7FC0_0000},
    {4'd10, 2'd3, 8'h80, 32'h7FC0_0000},
    {4'd10, 2'd3, 8'h00, 32'h7FC0_0000},
    {4'd4, 2'd0, 8'hB8, 32'hBFC0_0000}
  };

  function automatic string req_name(input logic [3:0] r);
    case (r)
      4'd4:    return "R4";
      4'd5:    return "R5";
      4'd6:    return "R6";
      4'd7:    return "R7";
      4'd8:    return "R8";
      4'd9:    return "R9";
      default: return "R10";
    endcase
  endfunction

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1'b1;
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  endtask

  initial begin
    #200000;
    errors++;
    $display("FAIL watchdog actual=timeout expected=completion");
    finish_run();
  end

  initial begin
    // R1: reset state
    repeat (3) @(negedge clk);
    check("R1", {31'h0, out_valid}, 32'h0);
    check("R1", out_word, 32'h0);
    rst_n = 1'b1;
    repeat (2) @(negedge clk);
    check("R1", {31'h0, out_valid}, 32'h0);
    check("R1", out_word, 32'h0);

    // Table walk: drive on a falling edge, sample one rising edge later.
    for (int i = 0; i < NV; i++) begin
      in_valid = 1'b1;
      in_fmt   = VEC[i][41:40];
      in_code  = VEC[i][39:32];
      @(negedge clk);
      check("R2", {31'h0, out_valid}, 32'h1);
      check(req_name(VEC[i][45:42]), out_word, VEC[i][31:0]);
    end

    // R2 and R3: idle cycles with changing code keep the last word.
    in_valid = 1'b1; in_fmt = 2'd1; in_code = 8'h77;
    @(negedge clk);
    check("R9", out_word, 32'h4370_0000);
    in_valid = 1'b0; in_fmt = 2'd2; in_code = 8'h01;
    @(negedge clk);
    check("R2", {31'h0, out_valid}, 32'h0);
    check("R3", out_word, 32'h4370_0000);
    in_code = 8'h7C; in_fmt = 2'd3;
    repeat (3) @(negedge clk);
    check("R3", out_word, 32'h4370_0000);
    check("R2", {31'h0, out_valid}, 32'h0);

    // R2: back-to-back stream, each result one cycle behind its code.
    in_valid = 1'b1; in_fmt = 2'd2; in_code = 8'h01;
    @(negedge clk);
    check("R5", out_word, 32'h3780_0000);
    in_fmt = 2'd0; in_code = 8'h01;
    @(negedge clk);
    check("R5", out_word, 32'h3C80_0000);
    in_valid = 1'b0;
    @(negedge clk);
    check("R2", {31'h0, out_valid}, 32'h0);

    // R1: reset mid-run clears the result.
    rst_n = 1'b0;
    @(negedge clk);
    check("R1", out_word, 32'h0);
    check("R1", {31'h0, out_valid}, 32'h0);
    rst_n = 1'b1;
    @(negedge clk);
    finish_run();
  end

endmodule